// File: doc/BRIEF.md
# Repeat-Prefix Iteration Controller

This block sequences a string instruction that carries a repeat prefix. When an instruction is issued it decides whether the instruction repeats. A repeating instruction runs as a loop: a strobe goes to the execution unit, the controller waits for the execution unit to report completion, takes one off the count, and then decides whether to stop. The string operation itself happens outside the block. The block only supplies the iteration strobes, the new count and the updated instruction pointer.

Two repeat encodings are recognised. For compare and scan style operations they have opposite exit conditions on the zero flag. The count uses all 32 bits under 32-bit address size and only its low half under 16-bit address size. An asynchronous event that is pending between iterations makes the controller yield to the event prioritizer without retiring. The instruction pointer therefore stays on the repeated instruction, and execution later resumes there with the remaining count.

Top module: `rep_iter_ctrl`

## Requirements
- R1: With prefix 0xF3 on a zero-flag-sensitive operation, the repeat retires after an iteration that returns zero flag 0.
- R2: With prefix 0xF2 on a zero-flag-sensitive operation, the repeat retires after an iteration that returns zero flag 1.
- R3: On an operation that is not zero-flag-sensitive, the returned zero flag has no effect, and the loop runs until the count is exhausted.
- R4: When `addr32`=1 the whole 32-bit count is tested and decremented, with a borrow across bit 16. When `addr32`=0 only bits [15:0] are tested and decremented, and bits [31:16] of `count_out` keep their issued value.
- R5: A repeating instruction issued with an effective count of zero gets no `exec_go`. It retires one cycle after issue, and the pointer advances.
- R6: Each executed iteration lowers the count by exactly one. The value appears on `count_out` with a `count_we` pulse, and the loop retires when the count reaches zero.
- R7: `ip_we` pulses exactly once per retired instruction, with `ip_out` = issued pointer + `ilen`. A yield writes no pointer.
- R8: If `async_pending` is high after an iteration that does not end the repeat, `yield` pulses with no `ip_we`, and the count written so far is kept. An iteration that ends the repeat retires even while an event is pending.
- R9: A prefix other than 0xF2/0xF3, or `repeatable`=0, gives exactly one `exec_go`, one retire, and no count write.
- R10: After reset `exec_go`, `retire`, `yield`, `ip_we`, `count_we` and `busy` are all low.
- R11: The exit test uses the zero flag sampled in the cycle `exec_done` is high, not its later value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Issue an instruction (ignored while busy) |
| prefix | input | 8 | Repeat prefix byte |
| repeatable | input | 1 | Instruction accepts a repeat prefix |
| zf_sensitive | input | 1 | Operation also exits on the zero flag |
| addr32 | input | 1 | 1 = 32-bit count, 0 = 16-bit count |
| ilen | input | 4 | Instruction length in bytes |
| count_in | input | 32 | Count register value at issue |
| ip_in | input | 32 | Instruction pointer of the instruction |
| exec_done | input | 1 | Execution unit finished the current iteration |
| zf_in | input | 1 | Zero flag, valid with exec_done |
| async_pending | input | 1 | An asynchronous event is waiting |
| exec_go | output | 1 | One-cycle strobe: run one iteration |
| count_out | output | 32 | Updated count register |
| count_we | output | 1 | count_out carries a new value |
| ip_out | output | 32 | Advanced instruction pointer |
| ip_we | output | 1 | ip_out is valid |
| yield | output | 1 | Loop suspended for an event, not retired |
| retire | output | 1 | Instruction finished |
| busy | output | 1 | An instruction is in progress |

## Verification
The hardest situation to reach is an event arriving at exactly the iteration boundary. The bench raises `async_pending` in the same cycle it returns `exec_done` for a chosen iteration number, so the flag is seen on the very next decision. It does this once where the count still has iterations left, and once where that iteration drains the count, which separates yield from retire. The bench also inverts `zf_in` in every cycle except the completion cycle, so logic that reads the live flag takes the wrong exit.

// File: rtl/rep_pkg.sv
package rep_pkg;
  localparam int CNT_W    = 32;
  localparam int CNT_LO_W = 16;
  localparam logic [7:0] PFX_REPZ  = 8'hF3;
  localparam logic [7:0] PFX_REPNZ = 8'hF2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_CHECK = 2'd2
  } rep_state_e;

  function automatic logic is_rep_prefix(input logic [7:0] p);
    return (p == PFX_REPZ) || (p == PFX_REPNZ);
  endfunction

  function automatic logic cnt_is_zero(input logic [CNT_W-1:0] c, input logic wide);
    if (wide) return (c == '0);
    return (c[CNT_LO_W-1:0] == '0);
  endfunction

  function automatic logic [CNT_W-1:0] cnt_dec(input logic [CNT_W-1:0] c, input logic wide);
    logic [CNT_LO_W-1:0] lo;
    if (wide) return c - 1'b1;
    lo = c[CNT_LO_W-1:0] - 1'b1;
    return {c[CNT_W-1:CNT_LO_W], lo};
  endfunction

  // F3 leaves on a clear flag, F2 on a set flag
  function automatic logic zf_exit(input logic repz, input logic zf);
    return repz ? ~zf : zf;
  endfunction
endpackage

// File: rtl/rep_decode.sv
module rep_decode
  import rep_pkg::*;
(
  input  logic [7:0]       prefix,
  input  logic             repeatable,
  input  logic             addr32,
  input  logic [CNT_W-1:0] count_in,
  output logic             rep_mode,
  output logic             repz,
  output logic             start_zero
);
  always_comb begin
    rep_mode   = repeatable && is_rep_prefix(prefix);
    repz       = (prefix == PFX_REPZ);
    start_zero = cnt_is_zero(count_in, addr32);
  end
endmodule

// File: rtl/rep_counter.sv
module rep_counter
  import rep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             load_wide,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cnt_zero_next
);
  logic wide_q;
  logic [CNT_W-1:0] cnt_dec_val;

  always_comb begin
    cnt_dec_val   = cnt_dec(cnt_q, wide_q);
    cnt_zero_next = cnt_is_zero(cnt_q, wide_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wide_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= load_val;
      wide_q <= load_wide;
    end else if (dec) begin
      cnt_q  <= cnt_dec_val;
    end
  end

  // R4
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && !wide_q) |=> (cnt_q[CNT_W-1:CNT_LO_W] == $past(cnt_q[CNT_W-1:CNT_LO_W])));
  // R6
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && wide_q) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/rep_fsm.sv
module rep_fsm
  import rep_pkg::*;
#(
  parameter int IP_W  = 32,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rep_mode,
  input  logic             repz,
  input  logic             start_zero,
  input  logic             zf_sensitive,
  input  logic [LEN_W-1:0] ilen,
  input  logic [IP_W-1:0]  ip_in,
  input  logic             exec_done,
  input  logic             zf_in,
  input  logic             async_pending,
  input  logic             cnt_zero,
  output logic             load,
  output logic             dec,
  output logic             exec_go,
  output logic             count_we,
  output logic [IP_W-1:0]  ip_out,
  output logic             ip_we,
  output logic             yield,
  output logic             retire,
  output logic             busy
);
  rep_state_e state_q;
  logic rep_q, repz_q, zfs_q, zf_q;
  logic [LEN_W-1:0] ilen_q;
  logic [IP_W-1:0]  ip_q;
  logic accept, iter_done, stop_now;

  always_comb begin
    accept    = (state_q == ST_IDLE) && start;
    iter_done = (state_q == ST_WAIT) && exec_done;
    load      = accept;
    dec       = iter_done && rep_q;
    stop_now  = cnt_zero || (zfs_q && zf_exit(repz_q, zf_q));
    busy      = (state_q != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      rep_q    <= 1'b0;
      repz_q   <= 1'b0;
      zfs_q    <= 1'b0;
      zf_q     <= 1'b0;
      ilen_q   <= '0;
      ip_q     <= '0;
      ip_out   <= '0;
      exec_go  <= 1'b0;
      count_we <= 1'b0;
      ip_we    <= 1'b0;
      yield    <= 1'b0;
      retire   <= 1'b0;
    end else begin
      exec_go  <= 1'b0;
      count_we <= 1'b0;
      ip_we    <= 1'b0;
      yield    <= 1'b0;
      retire   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          rep_q  <= rep_mode;
          repz_q <= repz;
          zfs_q  <= zf_sensitive;
          ilen_q <= ilen;
          ip_q   <= ip_in;
          if (rep_mode && start_zero) begin
            retire <= 1'b1;
            ip_we  <= 1'b1;
            ip_out <= ip_in + IP_W'(ilen);
          end else begin
            exec_go <= 1'b1;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: if (exec_done) begin
          zf_q <= zf_in;
          if (rep_q) begin
            count_we <= 1'b1;
            state_q  <= ST_CHECK;
          end else begin
            retire  <= 1'b1;
            ip_we   <= 1'b1;
            ip_out  <= ip_q + IP_W'(ilen_q);
            state_q <= ST_IDLE;
          end
        end
        ST_CHECK: begin
          if (stop_now) begin
            retire  <= 1'b1;
            ip_we   <= 1'b1;
            ip_out  <= ip_q + IP_W'(ilen_q);
            state_q <= ST_IDLE;
          end else if (async_pending) begin
            yield   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            exec_go <= 1'b1;
            state_q <= ST_WAIT;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7
  end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exec_go, retire, yield}));
  // R8
  yield_no_ip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    yield |-> !ip_we);
  // R5
  zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rep_mode && start_zero) |=> (retire && !exec_go));
  // R9
  single_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_done && !rep_q) |=> (retire && !count_we));
  // R6
  dec_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |=> count_we);
endmodule

// File: rtl/rep_iter_ctrl.sv
module rep_iter_ctrl
  import rep_pkg::*;
#(
  parameter int IP_W  = 32,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       prefix,
  input  logic             repeatable,
  input  logic             zf_sensitive,
  input  logic             addr32,
  input  logic [LEN_W-1:0] ilen,
  input  logic [CNT_W-1:0] count_in,
  input  logic [IP_W-1:0]  ip_in,
  input  logic             exec_done,
  input  logic             zf_in,
  input  logic             async_pending,
  output logic             exec_go,
  output logic [CNT_W-1:0] count_out,
  output logic             count_we,
  output logic [IP_W-1:0]  ip_out,
  output logic             ip_we,
  output logic             yield,
  output logic             retire,
  output logic             busy
);
  logic rep_mode, repz, start_zero, cnt_zero, load, dec;

  rep_decode u_dec (
    .prefix(prefix), .repeatable(repeatable), .addr32(addr32), .count_in(count_in),
    .rep_mode(rep_mode), .repz(repz), .start_zero(start_zero)
  );

  rep_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(count_in), .load_wide(addr32),
    .dec(dec), .cnt_q(count_out), .cnt_zero_next(cnt_zero)
  );

  rep_fsm #(.IP_W(IP_W), .LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .rep_mode(rep_mode), .repz(repz),
    .start_zero(start_zero), .zf_sensitive(zf_sensitive), .ilen(ilen), .ip_in(ip_in),
    .exec_done(exec_done), .zf_in(zf_in), .async_pending(async_pending),
    .cnt_zero(cnt_zero), .load(load), .dec(dec), .exec_go(exec_go),
    .count_we(count_we), .ip_out(ip_out), .ip_we(ip_we), .yield(yield),
    .retire(retire), .busy(busy)
  );
endmodule

// File: tb/rep_iter_ctrl_tb.sv
module rep_iter_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, repeatable = 0, zf_sensitive = 0, addr32 = 0;
  logic [7:0] prefix = 0;
  logic [3:0] ilen = 0;
  logic [31:0] count_in = 0, ip_in = 0;
  logic exec_done = 0, zf_in = 0, async_pending = 0;
  logic exec_go, count_we, ip_we, yield, retire, busy;
  logic [31:0] count_out, ip_out;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  rep_iter_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .prefix(prefix), .repeatable(repeatable),
    .zf_sensitive(zf_sensitive), .addr32(addr32), .ilen(ilen), .count_in(count_in),
    .ip_in(ip_in), .exec_done(exec_done), .zf_in(zf_in), .async_pending(async_pending),
    .exec_go(exec_go), .count_out(count_out), .count_we(count_we), .ip_out(ip_out),
    .ip_we(ip_we), .yield(yield), .retire(retire), .busy(busy)
  );

  typedef struct packed {
    logic [7:0]  pfx;
    logic        rep;
    logic        zfs;
    logic        a32;
    logic [3:0]  len;
    logic [31:0] cnt;
    logic [7:0]  pat;      // zero flag returned by iteration i in bit i
    logic [3:0]  async_at; // iteration after which an event waits, 0 = none
    logic [7:0]  x_execs;
    logic [31:0] x_cnt;
    logic        x_ret;    // 1 retire, 0 yield
  } row_t;

  localparam int NROWS = 13;
  localparam row_t TABLE [NROWS] = '{
    '{8'hF3,1,0,1,4'd2,32'd5,8'h00,4'd0,8'd5,32'd0,1},           // R6
    '{8'hF3,1,1,1,4'd2,32'd8,8'h03,4'd0,8'd3,32'd5,1},           // R1
    '{8'hF2,1,1,1,4'd3,32'd8,8'h08,4'd0,8'd4,32'd4,1},           // R2
    '{8'hF2,1,0,1,4'd1,32'd3,8'hFF,4'd0,8'd3,32'd0,1},           // R3
    '{8'hF3,1,1,1,4'd2,32'd0,8'h00,4'd0,8'd0,32'd0,1},           // R5
    '{8'hF3,1,0,0,4'd2,32'hABCD0002,8'h00,4'd0,8'd2,32'hABCD0000,1}, // R4
    '{8'hF3,1,0,0,4'd5,32'h00050000,8'h00,4'd0,8'd0,32'h00050000,1}, // R4
    '{8'h66,1,0,1,4'd2,32'd4,8'h00,4'd0,8'd1,32'd4,1},           // R9
    '{8'hF3,0,0,1,4'd6,32'd4,8'h00,4'd0,8'd1,32'd4,1},           // R9
    '{8'hF3,1,0,1,4'd2,32'd6,8'h00,4'd2,8'd2,32'd4,0},           // R8
    '{8'hF3,1,1,1,4'd2,32'd1,8'h00,4'd0,8'd1,32'd0,1},           // R11
    '{8'hF3,1,0,1,4'd2,32'd2,8'h00,4'd2,8'd2,32'd0,1},           // R8
    '{8'hF3,1,1,1,4'd7,32'h00010000,8'h00,4'd0,8'd1,32'h0000FFFF,1}  // R4
  };

  function automatic string req_of(int r);
    case (r)
      0: return "R6";  1: return "R1";  2: return "R2";  3: return "R3";
      4: return "R5";  5, 6, 12: return "R4";
      7, 8: return "R9"; 9, 11: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_row(int r);
    row_t v = TABLE[r];
    int execs = 0, ipw = 0, cyc = 0;
    logic fin = 0, got_ret = 0;
    logic [31:0] rec_cnt = v.cnt, rec_ip = 32'h1000;
    @(negedge clk);
    prefix = v.pfx; repeatable = v.rep; zf_sensitive = v.zfs; addr32 = v.a32;
    ilen = v.len; count_in = v.cnt; ip_in = 32'h1000; start = 1;
    @(negedge clk);
    start = 0;
    while (!fin && cyc < 300) begin
      cyc++;
      if (count_we) rec_cnt = count_out;
      if (ip_we) begin rec_ip = ip_out; ipw++; end
      if (retire) begin fin = 1; got_ret = 1; end
      if (yield) fin = 1;
      exec_done = 0;
      zf_in = ~zf_in;
      if (exec_go) begin
        exec_done = 1;
        zf_in = v.pat[execs[2:0]];
        execs++;
        if (execs == int'(v.async_at)) async_pending = 1;
      end
      if (!fin) @(negedge clk);
    end
    async_pending = 0;
    exec_done = 0;
    chk(req_of(r), "iterations", 32'(execs), 32'(v.x_execs));
    chk(req_of(r), "count", rec_cnt, v.x_cnt);
    chk(req_of(r), "retired", 32'(got_ret), 32'(v.x_ret));
    chk("R7", "pointer", rec_ip, v.x_ret ? 32'h1000 + 32'(v.len) : 32'h1000);
    chk("R7", "pointer writes", 32'(ipw), 32'(v.x_ret));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "strobes in reset", {26'd0, exec_go, retire, yield, ip_we, count_we, busy}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R10", "strobes after reset", {26'd0, exec_go, retire, yield, ip_we, count_we, busy}, 32'd0);
    for (int r = 0; r < NROWS; r++) run_row(r);
    // R8 resume after yield: reissue with the remaining count
    @(negedge clk);
    prefix = 8'hF3; repeatable = 1; zf_sensitive = 0; addr32 = 1; ilen = 2;
    count_in = 32'd4; ip_in = 32'h1000; start = 1;
    @(negedge clk); start = 0;
    begin
      int n = 0; int c = 0; logic done_seen = 0;
      while (!done_seen && c < 100) begin
        c++;
        if (retire) done_seen = 1;
        exec_done = exec_go;
        if (exec_go) n++;
        if (!done_seen) @(negedge clk);
      end
      exec_done = 0;
      chk("R8", "resumed iterations", 32'(n), 32'd4);
      chk("R8", "resumed pointer", ip_out, 32'h1002);
    end
    @(negedge clk);
    chk("R10", "idle after run", {31'd0, busy}, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule